// File: doc/BRIEF.md
# Context status ring writer

This block keeps a small ring of 64-bit context-status records and a pointer register that tells software where the newest record sits. An upstream scheduler presents one status event per cycle on a valid/data strobe. The block stores each event at the next ring slot and moves its write pointer there. It then raises a one-cycle interrupt pulse, unless the event carries a flag asking for the interrupt to be held back. Callers use that flag when they emit two records back to back and want only the second one to interrupt.

The write pointer starts at 7, which means the ring is still empty. The first event always lands in slot 0. After that the pointer steps by one and wraps from the last slot back to 0. Software sees the ring and the pointer register through a word-addressed port. Software may read any word, and may write the read-pointer and mask fields of the pointer register. The write pointer is owned by the block and software cannot change it. A sticky overflow flag shows that the writer has stepped onto the slot software last marked as read.

Top module: `ctx_status_ring`

## Requirements
- R1: After reset, the pointer register reads 0x0000_0707: write pointer 7, read pointer 7, mask 0. Every ring word reads 0, and both irqPulse and overflow are low.
- R2: When the write pointer is 7, an accepted event (evtValid high at a clock edge) is stored in slot 0, and the write pointer becomes 0.
- R3: When the write pointer is 0..ENTRIES-2, an accepted event moves it up by one. When it is ENTRIES-1, an accepted event moves it to 0. With no event, the write pointer holds its value.
- R4: Slot n is stored as two 32-bit words. Word address 2n holds evtData[31:0], the status flags: bit 0 idle-to-active, bit 1 preempted, bit 2 element switch, bit 3 active-to-idle, bit 4 context complete, bit 15 lite-restore. Word address 2n+1 holds evtData[63:32], the context ID. The event is stored bit for bit.
- R5: An accepted event with evtDefer low drives irqPulse high for exactly the cycle after the accepting edge. In that same cycle, the new slot contents and the new write pointer are already readable.
- R6: An accepted event with evtDefer high still updates the slot and the write pointer, but irqPulse stays low.
- R7: The pointer register sits at word address 2*ENTRIES. Its layout is write pointer in bits 2:0, read pointer in bits 10:8, mask in bits 31:16, and zeros in all other bits. A software write to it loads only the read pointer and the mask; the write-pointer bits of the written value are ignored.
- R8: overflow becomes 1 after an accepted event whose new write pointer equals the read pointer while the read pointer is not 7. Once set, it stays 1 until reset.
- R9: Software writes to ring word addresses have no effect on stored data. Reads of word addresses above 2*ENTRIES return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Status event present this cycle |
| evtDefer | input | 1 | Suppress the interrupt for this event |
| evtData | input | 64 | Status event: flags in the low word, context ID in the high word |
| swAddr | input | ADDR_W (4) | Software word address |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 32 | Software write data |
| swRdData | output | 32 | Software read data for swAddr (combinational from stored state) |
| irqPulse | output | 1 | One-cycle context-switch interrupt |
| overflow | output | 1 | Sticky: writer caught up with the read pointer |

## Verification
Directed runs first check the empty-ring start, where 7 must step to slot 0. They then send a burst long enough to wrap past the last slot, which separates modulo-ENTRIES stepping from plain 3-bit counting. A deferred event checks that storing the record and raising the interrupt are handled separately. A pointer-register write whose data has the write-pointer bits set to 1 checks that the write pointer is protected. Setting a real read pointer and continuing the stream checks that overflow is raised on the exact step that lands on it and not before. A seeded random mix then interleaves events, pointer writes, ignored ring writes, idle cycles and reads of every address, all compared against a bench model of the ring.

// File: rtl/ctx_status_pkg.sv
package ctx_status_pkg;

  // Pointer fields are three bits wide; this is fixed by the register layout.
  localparam int PTR_W   = 3;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 2 * WORD_W;

  // Pointer value that means no slot has been written yet.
  localparam logic [PTR_W-1:0] IDLE_PTR = '1;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic             wrStrobe;
    logic [PTR_W-1:0] wrIdx;
  } ring_strobe_t;

endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import ctx_status_pkg::*;
#(
  parameter int ENTRIES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evtValid,
  input  logic             evtDefer,
  input  logic [PTR_W-1:0] rdPtr,
  output ring_strobe_t     strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic             irqPulse,
  output logic             overflow
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] nextPtr;
  logic             hitRead;

  always_comb begin
    if (wrPtr == IDLE_PTR || wrPtr == LAST_IDX) nextPtr = '0;
    else                                        nextPtr = wrPtr + 1'b1;
  end

  assign hitRead       = (rdPtr != IDLE_PTR) && (nextPtr == rdPtr);
  assign strobe.wrStrobe = evtValid;
  assign strobe.wrIdx    = nextPtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr    <= IDLE_PTR;
      irqPulse <= 1'b0;
      overflow <= 1'b0;
    end else begin
      irqPulse <= evtValid && !evtDefer;
      if (evtValid) begin
        wrPtr <= nextPtr;
        if (hitRead) overflow <= 1'b1;
      end
    end
  end

  // R2: the first event after an empty ring goes to slot 0
  p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && wrPtr == IDLE_PTR |=> wrPtr == '0);

  // R3: wrap from the last slot back to 0
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && wrPtr == LAST_IDX |=> wrPtr == '0);

  // R3: single step inside the ring
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && wrPtr != IDLE_PTR && wrPtr < LAST_IDX
      |=> wrPtr == PTR_W'($past(wrPtr) + 3'd1));

  // R3: pointer holds without an event
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> $stable(wrPtr));

  // R3: pointer is either idle or a legal slot
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrPtr == IDLE_PTR || wrPtr <= LAST_IDX);

  // R5: non-deferred event pulses the interrupt next cycle
  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && !evtDefer |=> irqPulse);

  // R6: deferred event keeps the interrupt low
  p_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && evtDefer |=> !irqPulse);

  // R8: overflow is sticky
  p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: rtl/csr_data.sv
module csr_data
  import ctx_status_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ring_strobe_t       strobe,
  input  logic [ENTRY_W-1:0] evtData,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [ADDR_W-1:0]  swAddr,
  input  logic               swWrEn,
  input  logic [WORD_W-1:0]  swWrData,
  output logic [WORD_W-1:0]  swRdData,
  output logic [PTR_W-1:0]   rdPtr
);

  localparam logic [ADDR_W-1:0] PTR_ADDR = ADDR_W'(2 * ENTRIES);

  logic [ENTRY_W-1:0] slotMem [ENTRIES];
  logic [15:0]        maskReg;
  logic               ptrWrite;

  assign ptrWrite = swWrEn && (swAddr == PTR_ADDR);

  // One storage register per slot.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slotMem[g] <= '0;
      else if (strobe.wrStrobe && strobe.wrIdx == PTR_W'(g))
        slotMem[g] <= evtData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr   <= IDLE_PTR;
      maskReg <= '0;
    end else if (ptrWrite) begin
      rdPtr   <= swWrData[10:8];
      maskReg <= swWrData[31:16];
    end
  end

  always_comb begin
    swRdData = '0;
    if (swAddr == PTR_ADDR)
      swRdData = {maskReg, 5'b0, rdPtr, 5'b0, wrPtr};
    for (int i = 0; i < ENTRIES; i++) begin
      if (swAddr == ADDR_W'(2 * i))     swRdData = slotMem[i][WORD_W-1:0];
      if (swAddr == ADDR_W'(2 * i + 1)) swRdData = slotMem[i][ENTRY_W-1:WORD_W];
    end
  end

  // R7: software write loads the read pointer field
  p_rdptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptrWrite |=> rdPtr == $past(swWrData[10:8]));

  // R7: read pointer moves only on a software write
  p_rdptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ptrWrite |=> $stable(rdPtr));

  // R5: a written event is readable one cycle after acceptance
  p_slot_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrStrobe && strobe.wrIdx == '0 |=> slotMem[0] == $past(evtData));

endmodule

// File: rtl/ctx_status_ring.sv
module ctx_status_ring
  import ctx_status_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtValid,
  input  logic              evtDefer,
  input  logic [63:0]       evtData,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic              swWrEn,
  input  logic [31:0]       swWrData,
  output logic [31:0]       swRdData,
  output logic              irqPulse,
  output logic              overflow
);

  ring_strobe_t     strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  csr_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evtValid (evtValid),
    .evtDefer (evtDefer),
    .rdPtr    (rdPtr),
    .strobe   (strobe),
    .wrPtr    (wrPtr),
    .irqPulse (irqPulse),
    .overflow (overflow)
  );

  csr_data #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) data_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .evtData  (evtData),
    .wrPtr    (wrPtr),
    .swAddr   (swAddr),
    .swWrEn   (swWrEn),
    .swWrData (swWrData),
    .swRdData (swRdData),
    .rdPtr    (rdPtr)
  );

endmodule

// File: tb/ctx_status_ring_tb_top.sv
module ctx_status_ring_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 6;
  localparam int ADDR_W     = 4;
  localparam int PTR_ADDR   = 2 * ENTRIES;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evtValid = 1'b0;
  logic              evtDefer = 1'b0;
  logic [63:0]       evtData = '0;
  logic [ADDR_W-1:0] swAddr = '0;
  logic              swWrEn = 1'b0;
  logic [31:0]       swWrData = '0;
  logic [31:0]       swRdData;
  logic              irqPulse;
  logic              overflow;

  int checks = 0;
  int failures = 0;

  // Bench model of the ring
  logic [63:0] mSlot [ENTRIES];
  logic [2:0]  mWr, mRd;
  logic [15:0] mMask;
  logic        mOvf;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctx_status_ring #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtDefer(evtDefer),
    .evtData(evtData), .swAddr(swAddr), .swWrEn(swWrEn), .swWrData(swWrData),
    .swRdData(swRdData), .irqPulse(irqPulse), .overflow(overflow)
  );

  function automatic logic [2:0] stepPtr(input logic [2:0] p);
    if (p == 3'd7 || p == 3'(ENTRIES - 1)) return 3'd0;
    return p + 3'd1;
  endfunction

  function automatic logic [31:0] expWord(input int addr);
    if (addr == PTR_ADDR) return {mMask, 5'b0, mRd, 5'b0, mWr};
    if (addr < PTR_ADDR)
      return addr[0] ? mSlot[addr / 2][63:32] : mSlot[addr / 2][31:0];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic readWord(input int addr, output logic [31:0] d);
    swAddr = ADDR_W'(addr);
    #1;
    d = swRdData;
  endtask

  task automatic chkAddr(input string req, input int addr);
    logic [31:0] d;
    readWord(addr, d);
    chk(req, $sformatf("word %0d", addr), 64'(d), 64'(expWord(addr)));
  endtask

  task automatic sendEvent(input logic [63:0] data, input logic defer, input string req);
    logic [2:0] nxt;
    @(negedge clk);
    evtValid = 1'b1; evtDefer = defer; evtData = data;
    @(negedge clk);
    evtValid = 1'b0; evtDefer = 1'b0;
    nxt = stepPtr(mWr);
    if (mRd != 3'd7 && nxt == mRd) mOvf = 1'b1;
    mWr = nxt;
    mSlot[nxt] = data;
    chk(defer ? "R6" : "R5", "irqPulse", 64'(irqPulse), 64'(!defer));
    chk("R8", "overflow", 64'(overflow), 64'(mOvf));
    chkAddr(req, PTR_ADDR);
    chkAddr("R4", 2 * int'(nxt));
    chkAddr("R4", 2 * int'(nxt) + 1);
  endtask

  task automatic swWrite(input int addr, input logic [31:0] data, input string req);
    @(negedge clk);
    swWrEn = 1'b1; swAddr = ADDR_W'(addr); swWrData = data;
    @(negedge clk);
    swWrEn = 1'b0;
    if (addr == PTR_ADDR) begin
      mRd = data[10:8];
      mMask = data[31:16];
    end
    chk(req, "irqPulse idle", 64'(irqPulse), 64'h0);
    chkAddr(req, addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < ENTRIES; i++) mSlot[i] = '0;
    mWr = 3'd7; mRd = 3'd7; mMask = '0; mOvf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "irqPulse", 64'(irqPulse), 64'h0);
    chk("R1", "overflow", 64'(overflow), 64'h0);
    begin
      logic [31:0] d;
      readWord(PTR_ADDR, d);
      chk("R1", "pointer reg", 64'(d), 64'h0000_0707);
    end
    for (int a = 0; a < PTR_ADDR; a++) chkAddr("R1", a);
    // R9: unmapped addresses read zero
    for (int a = PTR_ADDR + 1; a < 16; a++) chkAddr("R9", a);

    // R2: first event from the empty ring
    sendEvent({32'h0000_00A1, 32'h0000_0001}, 1'b0, "R2");
    // R3: walk past the last slot
    for (int k = 0; k < ENTRIES + 1; k++)
      sendEvent({32'h1000_0000 + 32'(k), 32'h0000_8010 | 32'(k)}, 1'b0, "R3");
    // R6: deferred event still stored
    sendEvent({32'hDEF0_0001, 32'h0000_0018}, 1'b1, "R6");
    sendEvent({32'hDEF0_0002, 32'h0000_0001}, 1'b0, "R5");

    // R9: writes to ring words are ignored
    swWrite(0, 32'hFFFF_FFFF, "R9");
    swWrite(5, 32'h1234_5678, "R9");

    // R7: write pointer bits in the written value are ignored
    swWrite(PTR_ADDR, {16'hBEEF, 5'b11111, 3'd2, 5'b11111, 3'b111}, "R7");

    // R8: stream until the writer lands on read pointer 2
    for (int k = 0; k < ENTRIES + 1; k++)
      sendEvent({32'h2000_0000 + 32'(k), 32'h0000_0004}, 1'b0, "R8");

    // Seeded random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op <= 5) begin
        sendEvent({$urandom, $urandom}, $urandom_range(0, 3) == 0, "R3");
      end else if (op == 6) begin
        logic [31:0] w;
        w = $urandom;
        if ($urandom_range(0, 1) == 0) w[10:8] = 3'd7;
        swWrite(PTR_ADDR, w, "R7");
      end else if (op == 7) begin
        swWrite(int'($urandom_range(0, PTR_ADDR - 1)), $urandom, "R9");
      end else if (op == 8) begin
        chkAddr("R4", int'($urandom_range(0, 15)));
      end else begin
        @(negedge clk);
        chk("R5", "irqPulse idle", 64'(irqPulse), 64'h0);
        chk("R3", "pointer idle", 64'(expWord(PTR_ADDR)), 64'(expWord(PTR_ADDR)));
        chkAddr("R3", PTR_ADDR);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule